// File: doc/BRIEF.md
# Address Decode Window Unit

This block turns a 32-bit physical address into a target ID, an attribute byte and a possibly translated address. The rules for this come from eight programmable decode windows. Each window covers a naturally aligned, power-of-two region of at least 64 KB. A packed control word per window holds a size mask, the attribute, the target and an enable bit. A separate base register places the window in the address space. Only the four lowest windows carry remap registers, and so only they can move the region to another base. The other windows forward the address unchanged.

Software sets up the windows through a word-addressed register port with a write strobe and a combinational read. The lookup port accepts one address per clock. It returns hit, target, attribute and translated address one cycle later. When several enabled windows claim the same address, the lowest-numbered window is used.

Top module: `addr_win_unit`

## Requirements
- R1: The register port is word addressed. `reg_addr_i[4:2]` selects the window (0 to 7) and `reg_addr_i[1:0]` selects the register: 0 is control, 1 is base, 2 is remap low, 3 is remap high.
- R2: Control register layout: bit 0 is the enable, bits [7:4] are the target, bits [15:8] are the attribute and bits [31:16] are the size mask (size/64 KB − 1). Bits [3:1] are not stored and read back as zero.
- R3: The base and remap-low registers keep only bits [31:16]. Their bits [15:0] read back as zero whatever was written.
- R4: After reset every register reads zero, and every lookup misses.
- R5: An enabled window matches when `(addr[31:16] & ~size) == (base[31:16] & ~size)`.
- R6: A window whose enable bit is clear never matches, whatever its base and size.
- R7: When several enabled windows match, the lookup reports the target, attribute and translation of the lowest-numbered one.
- R8: A hit in windows 0 to 3 returns `{remap[31:16] | (addr[31:16] & size), addr[15:0]}` as the translated address.
- R9: Windows 4 to 7 never translate: a hit there returns the input address. Their remap-low and remap-high offsets read zero, and writes to those offsets change nothing.
- R10: Remap high on windows 0 to 3 stores all 32 bits and reads them back. It has no effect on any lookup.
- R11: On a miss, `lk_hit_o` is 0, target and attribute are 0, and the translated address equals the input address.
- R12: Lookup results appear one clock after the address is sampled. A register write sampled at the same edge as a lookup does not affect that lookup, but it does affect the lookup sampled at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Word address: window index [4:2], register select [1:0] |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` (combinational) |
| lk_addr_i | input | 32 | Lookup address |
| lk_hit_o | output | 1 | Lookup hit, one cycle later |
| lk_target_o | output | 4 | Target ID of the selected window |
| lk_attr_o | output | 8 | Attribute of the selected window |
| lk_addr_o | output | 32 | Translated address |

## Verification
Directed lookups probe one 16 MB remapped window at its first and last bytes and one byte past each end. This separates a correct mask compare from off-by-one limit errors, and it shows whether the offset bits under the mask survive translation. Overlapping windows (a disabled one, a remapped one and a 64 KB pass-through one, all on the same base) are enabled and disabled in turn. That shows both the enable gating and the lowest-index priority, and each case has a visibly different result. A write and a lookup sampled at the same edge check the one-cycle visibility rule. A long random phase follows, with arbitrary control words and addresses steered near the programmed bases, compared every clock against a behavioural model. It covers irregular masks, reads of every offset and mixed write and lookup traffic.

// File: rtl/addr_win_pkg.sv
package addr_win_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned HW = 16;

  typedef enum logic [1:0] {
    OFS_CTRL = 2'd0,
    OFS_BASE = 2'd1,
    OFS_RLO  = 2'd2,
    OFS_RHI  = 2'd3
  } reg_ofs_e;

  typedef struct packed {
    logic [HW-1:0] size_m;
    logic [7:0]    attr;
    logic [3:0]    tgt;
    logic          en;
  } win_ctrl_t;
endpackage

// File: rtl/addr_win_regs.sv
module addr_win_regs
  import addr_win_pkg::*;
#(
  parameter int unsigned NUM_WIN   = 8,
  parameter int unsigned NUM_REMAP = 4,
  localparam int unsigned IDXW     = $clog2(NUM_WIN),
  localparam int unsigned RAW      = IDXW + 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [RAW-1:0]  addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output win_ctrl_t       ctrl_o  [NUM_WIN],
  output logic [HW-1:0]   base_o  [NUM_WIN],
  output logic [HW-1:0]   remap_o [NUM_WIN]
);
  logic [IDXW-1:0] idx;
  reg_ofs_e        ofs;
  logic [DW-1:0]   rhi [NUM_WIN];
  logic            unused_wbits;

  assign idx = addr_i[RAW-1:2];
  assign ofs = reg_ofs_e'(addr_i[1:0]);
  assign unused_wbits = ^wdata_i[3:1];

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    logic sel;
    assign sel = we_i && (idx == IDXW'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ctrl_o[i] <= '0;
        base_o[i] <= '0;
      end else if (sel) begin
        if (ofs == OFS_CTRL) ctrl_o[i] <= {wdata_i[31:16], wdata_i[15:8], wdata_i[7:4], wdata_i[0]};
        if (ofs == OFS_BASE) base_o[i] <= wdata_i[31:16];
      end
    end

    if (i < NUM_REMAP) begin : g_remap
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          remap_o[i] <= '0;
          rhi[i]     <= '0;
        end else if (sel) begin
          if (ofs == OFS_RLO) remap_o[i] <= wdata_i[31:16];
          if (ofs == OFS_RHI) rhi[i]     <= wdata_i;
        end
      end
    end else begin : g_fixed
      assign remap_o[i] = '0;
      assign rhi[i]     = '0;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (idx == IDXW'(i)) begin
        unique case (ofs)
          OFS_CTRL: rdata_o = {ctrl_o[i].size_m, ctrl_o[i].attr, ctrl_o[i].tgt, 3'b000, ctrl_o[i].en};
          OFS_BASE: rdata_o = {base_o[i], 16'h0};
          OFS_RLO:  rdata_o = {remap_o[i], 16'h0};
          OFS_RHI:  rdata_o = rhi[i];
        endcase
      end
    end
  end

  // R3: a base write lands in the addressed window
  a_r3_base_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && ofs == OFS_BASE) |=> base_o[$past(idx)] == $past(wdata_i[31:16]));

  // R2: the enable bit follows bit 0 of a control write
  a_r2_ctrl_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && ofs == OFS_CTRL) |=> ctrl_o[$past(idx)].en == $past(wdata_i[0]));
endmodule

// File: rtl/addr_win_match.sv
module addr_win_match
  import addr_win_pkg::*;
#(
  parameter int unsigned NUM_WIN   = 8,
  parameter int unsigned NUM_REMAP = 4
) (
  input  logic [DW-1:0] addr_i,
  input  win_ctrl_t     ctrl_i  [NUM_WIN],
  input  logic [HW-1:0] base_i  [NUM_WIN],
  input  logic [HW-1:0] remap_i [NUM_WIN],
  output logic          hit_o   [NUM_WIN],
  output logic [DW-1:0] xlat_o  [NUM_WIN]
);
  logic [HW-1:0] pg;
  assign pg = addr_i[DW-1:HW];

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_cmp
    logic [HW-1:0] keep;
    assign keep     = ~ctrl_i[i].size_m;
    assign hit_o[i] = ctrl_i[i].en && (((pg ^ base_i[i]) & keep) == '0);

    if (i < NUM_REMAP) begin : g_xl
      assign xlat_o[i] = {remap_i[i] | (pg & ctrl_i[i].size_m), addr_i[HW-1:0]};
    end else begin : g_pass
      logic [HW-1:0] unused_remap;
      assign unused_remap = remap_i[i];
      assign xlat_o[i]    = addr_i;
    end
  end
endmodule

// File: rtl/addr_win_pick.sv
module addr_win_pick
  import addr_win_pkg::*;
#(
  parameter int unsigned NUM_WIN = 8,
  localparam int unsigned IDXW   = $clog2(NUM_WIN)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] addr_i,
  input  logic          hit_i    [NUM_WIN],
  input  logic [DW-1:0] xlat_i   [NUM_WIN],
  input  win_ctrl_t     ctrl_i   [NUM_WIN],
  output logic          hit_o,
  output logic [3:0]    target_o,
  output logic [7:0]    attr_o,
  output logic [DW-1:0] addr_o
);
  logic            any;
  logic [IDXW-1:0] sel;

  // descending scan so the lowest index is taken last
  always_comb begin
    any = 1'b0;
    sel = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        any = 1'b1;
        sel = IDXW'(i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o    <= 1'b0;
      target_o <= '0;
      attr_o   <= '0;
      addr_o   <= '0;
    end else begin
      hit_o    <= any;
      target_o <= any ? ctrl_i[sel].tgt  : 4'h0;
      attr_o   <= any ? ctrl_i[sel].attr : 8'h0;
      addr_o   <= any ? xlat_i[sel]      : addr_i;
    end
  end

  logic hit_seen;
  always_comb begin
    hit_seen = 1'b0;
    for (int i = 0; i < NUM_WIN; i++) hit_seen |= hit_i[i];
  end

  // R12: hit reflects the window compare one cycle earlier
  a_r12_hit_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> hit_o == $past(hit_seen));
endmodule

// File: rtl/addr_win_unit.sv
module addr_win_unit
  import addr_win_pkg::*;
#(
  parameter int unsigned NUM_WIN   = 8,
  parameter int unsigned NUM_REMAP = 4,
  localparam int unsigned RAW      = $clog2(NUM_WIN) + 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_we_i,
  input  logic [RAW-1:0]  reg_addr_i,
  input  logic [31:0]     reg_wdata_i,
  output logic [31:0]     reg_rdata_o,
  input  logic [31:0]     lk_addr_i,
  output logic            lk_hit_o,
  output logic [3:0]      lk_target_o,
  output logic [7:0]      lk_attr_o,
  output logic [31:0]     lk_addr_o
);
  win_ctrl_t     ctrl  [NUM_WIN];
  logic [HW-1:0] base  [NUM_WIN];
  logic [HW-1:0] remap [NUM_WIN];
  logic          hit   [NUM_WIN];
  logic [DW-1:0] xlat  [NUM_WIN];

  addr_win_regs #(.NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .ctrl_o  (ctrl),
    .base_o  (base),
    .remap_o (remap)
  );

  addr_win_match #(.NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP)) u_match (
    .addr_i  (lk_addr_i),
    .ctrl_i  (ctrl),
    .base_i  (base),
    .remap_i (remap),
    .hit_o   (hit),
    .xlat_o  (xlat)
  );

  addr_win_pick #(.NUM_WIN(NUM_WIN)) u_pick (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (lk_addr_i),
    .hit_i    (hit),
    .xlat_i   (xlat),
    .ctrl_i   (ctrl),
    .hit_o    (lk_hit_o),
    .target_o (lk_target_o),
    .attr_o   (lk_attr_o),
    .addr_o   (lk_addr_o)
  );

  // R11: a miss carries no target or attribute
  a_r11_miss_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_hit_o |-> (lk_target_o == 4'h0 && lk_attr_o == 8'h0));
endmodule

// File: tb/addr_win_unit_tb.sv
module addr_win_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] lk_addr = '0;
  logic        lk_hit;
  logic [3:0]  lk_target;
  logic [7:0]  lk_attr;
  logic [31:0] lk_addr_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  addr_win_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .lk_addr_i(lk_addr),
    .lk_hit_o(lk_hit), .lk_target_o(lk_target), .lk_attr_o(lk_attr),
    .lk_addr_o(lk_addr_out)
  );

  // behavioural model state
  logic [31:0] m_ctrl [8];
  logic [31:0] m_base [8];
  logic [31:0] m_rlo  [8];
  logic [31:0] m_rhi  [8];

  function automatic logic [31:0] m_read(input logic [4:0] a);
    int w = int'(a[4:2]);
    case (a[1:0])
      2'd0: return m_ctrl[w];
      2'd1: return m_base[w];
      2'd2: return (w < 4) ? m_rlo[w] : 32'h0;
      default: return (w < 4) ? m_rhi[w] : 32'h0;
    endcase
  endfunction

  task automatic m_write(input logic [4:0] a, input logic [31:0] d);
    int w = int'(a[4:2]);
    case (a[1:0])
      2'd0: m_ctrl[w] = d & 32'hFFFF_FFF1;
      2'd1: m_base[w] = d & 32'hFFFF_0000;
      2'd2: if (w < 4) m_rlo[w] = d & 32'hFFFF_0000;
      default: if (w < 4) m_rhi[w] = d;
    endcase
  endtask

  task automatic m_lookup(input logic [31:0] a, output logic h, output logic [3:0] t,
                          output logic [7:0] at, output logic [31:0] xa);
    h = 1'b0; t = '0; at = '0; xa = a;
    for (int w = 0; w < 8; w++) begin
      logic [15:0] sz;
      sz = m_ctrl[w][31:16];
      if (!h && m_ctrl[w][0] && (((a[31:16] ^ m_base[w][31:16]) & ~sz) == 16'h0)) begin
        h  = 1'b1;
        t  = m_ctrl[w][7:4];
        at = m_ctrl[w][15:8];
        if (w < 4) xa = {m_rlo[w][31:16] | (a[31:16] & sz), a[15:0]};
      end
    end
  endtask

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // one clock: drive at negedge, check read, then check lookup one edge later
  task automatic step(input logic we, input logic [4:0] ra, input logic [31:0] wd,
                      input logic [31:0] la, input string tag);
    logic h; logic [3:0] t; logic [7:0] at; logic [31:0] xa;
    reg_we = we; reg_addr = ra; reg_wdata = wd; lk_addr = la;
    #1;
    chk(tag, "rdata", reg_rdata, m_read(ra));
    m_lookup(la, h, t, at, xa);
    if (we) m_write(ra, wd);
    @(negedge clk);
    chk(tag, "hit", 32'(lk_hit), 32'(h));
    chk(tag, "target", 32'(lk_target), 32'(t));
    chk(tag, "attr", 32'(lk_attr), 32'(at));
    chk(tag, "xaddr", lk_addr_out, xa);
  endtask

  function automatic logic [4:0] ra_of(input int w, input int o);
    return {3'(w), 2'(o)};
  endfunction

  task automatic wr(input int w, input int o, input logic [31:0] d, input string tag);
    step(1'b1, ra_of(w, o), d, 32'h0, tag);
  endtask

  task automatic look(input logic [31:0] a, input int w, input int o, input string tag);
    step(1'b0, ra_of(w, o), 32'h0, a, tag);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < 8; w++) begin
      m_ctrl[w] = '0; m_base[w] = '0; m_rlo[w] = '0; m_rhi[w] = '0;
    end
    repeat (3) @(negedge clk);
    chk("R4", "hit in reset", 32'(lk_hit), 32'h0);
    chk("R4", "xaddr in reset", lk_addr_out, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 and R1: every register reads zero, lookups miss (R11)
    for (int i = 0; i < 32; i++) look(32'h8000_0000 + 32'(i) * 32'h0011_0000, i / 4, i % 4, "R4");

    // R3 low bits dropped; R2 control reserved bits
    wr(0, 1, 32'h1234_5678, "R3");  look(32'h0, 0, 1, "R3");
    wr(0, 2, 32'hABCD_EF01, "R3");  look(32'h0, 0, 2, "R3");
    wr(0, 0, 32'hFFFF_FFFF, "R2");  look(32'h5555_0000, 0, 0, "R2");
    wr(0, 0, 32'h0000_0000, "R2");  look(32'h5555_0000, 0, 0, "R11");

    // R8: 16 MB remapped window 2
    wr(2, 1, 32'h8000_0000, "R8");
    wr(2, 2, 32'h1200_0000, "R8");
    wr(2, 0, 32'h00FF_E841, "R8");
    look(32'h8012_3456, 2, 0, "R8");
    look(32'h80FF_FFFF, 2, 2, "R8");
    look(32'h8000_0000, 2, 1, "R5");
    look(32'h8100_0000, 2, 0, "R5");
    look(32'h7FFF_FFFF, 2, 0, "R11");

    // R6: disabled window on same base
    wr(1, 1, 32'h8000_0000, "R6");
    wr(1, 0, 32'h00FF_1230, "R6");
    look(32'h8000_0010, 1, 0, "R6");

    // R7: window 5 overlaps window 2
    wr(5, 1, 32'h8000_0000, "R7");
    wr(5, 0, 32'h0000_5A71, "R7");
    look(32'h8000_1234, 5, 0, "R7");
    wr(2, 0, 32'h00FF_E840, "R7");
    look(32'h8000_1234, 5, 0, "R9");
    look(32'h8001_0000, 5, 0, "R5");

    // R9: remap offsets on high windows
    wr(5, 2, 32'hDEAD_0000, "R9");  look(32'h8000_0ABC, 5, 2, "R9");
    wr(5, 3, 32'hFEED_F00D, "R9");  look(32'h8000_0ABC, 5, 3, "R9");

    // R10: remap high stored, no lookup effect
    wr(2, 3, 32'hCAFE_BABE, "R10"); look(32'h0, 2, 3, "R10");
    wr(2, 0, 32'h00FF_E841, "R10");
    look(32'h80AB_CDEF, 2, 3, "R10");

    // R12: write and lookup at the same edge
    wr(3, 1, 32'h4000_0000, "R12");
    step(1'b1, ra_of(3, 0), 32'h0000_0011, 32'h4000_0000, "R12");
    look(32'h4000_0000, 3, 0, "R12");
    step(1'b1, ra_of(3, 0), 32'h0, 32'h4000_0000, "R12");
    look(32'h4000_0000, 3, 0, "R12");

    // random traffic against the model (R5)
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] la;
      int w;
      w  = $urandom_range(0, 7);
      la = $urandom;
      if ($urandom_range(0, 3) != 0) la[31:16] = m_base[w][31:16] ^ 16'($urandom_range(0, 255));
      if ($urandom_range(0, 7) == 0)
        step(1'b1, 5'($urandom_range(0, 31)), $urandom, la, "R5");
      else
        step(1'b0, 5'($urandom_range(0, 31)), 32'h0, la, "R5");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule